// File: doc/BRIEF.md
# Selectable serial baud clock generator

This block turns the system clock and two external timer overflow strobes into the bit-rate enables for a four-mode serial port. It does not output a divided clock. Each output is a one-cycle enable pulse in the system clock domain, and the shift logic uses it to advance by one bit. The transmit and receive directions each have their own divider chain. Because of this, one direction can run from the second timer while the other runs from the first, and the two can run at different rates.

Mode 0 is the synchronous shift mode. It divides the system clock by 12, or by 4 when the fast control is set, and both directions use that one divider. Mode 2 divides the system clock by 64, or by 32 when the double-rate control is set. Modes 1 and 3 count timer overflows: 32 overflows make one bit, or 16 when double-rate is set. When a direction is routed to the second timer, it always uses 32 overflows per bit. The receive direction also provides a 16x oversample tick for its bit sampler. Any change of mode, rate control or timer routing restarts all dividers from zero.

Top module: `baud_tick_gen`

## Requirements
- R1: After reset, with mode = 0 and fast = 0, tx_bit_en and rx_bit_en each pulse once every 12 clocks.
- R2: With mode = 0 and fast = 1, both bit enables pulse once every 4 clocks.
- R3: While mode = 0, rx_os_tick never pulses.
- R4: With mode = 2 (binary 10), the bit enables pulse every 64 clocks, or every 32 clocks when dbl_rate = 1. rx_os_tick pulses every 4 or 2 clocks respectively.
- R5: With mode = 1 or 3 and the first timer in use, a bit enable pulses once per 32 t1_ovf strobes, or once per 16 when dbl_rate = 1.
- R6: A direction whose second-timer select is 1 pulses once per 32 t2_ovf strobes, and dbl_rate has no effect on it.
- R7: t2_tx_sel affects only tx_bit_en and t2_rx_sel affects only rx_bit_en, so the two directions can run at different rates at the same time.
- R8: In modes 1 to 3, rx_os_tick pulses 16 times per receive bit period, and each rx_bit_en is preceded one cycle earlier by an rx_os_tick.
- R9: tx_bit_en and rx_bit_en are never high on two consecutive cycles.
- R10: A change of mode, dbl_rate, fast_sync, t2_tx_sel or t2_rx_sel clears every divider. The first pulse after a change therefore arrives a fixed time after the change, whatever the previous phase was.
- R11: While rst is high, and on the first cycle after it is released, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | Serial mode: 0 sync, 1 and 3 timer, 2 fixed |
| dbl_rate | input | 1 | Halves the period in modes 1 to 3 when the first timer is in use |
| fast_sync | input | 1 | Mode 0 divides by 4 instead of 12 |
| t1_ovf | input | 1 | First timer overflow strobe, one cycle |
| t2_ovf | input | 1 | Second timer overflow strobe, one cycle |
| t2_tx_sel | input | 1 | Transmit counts second timer overflows |
| t2_rx_sel | input | 1 | Receive counts second timer overflows |
| tx_bit_en | output | 1 | Transmit bit-rate enable pulse |
| rx_bit_en | output | 1 | Receive bit-rate enable pulse |
| rx_os_tick | output | 1 | Receive 16x oversample tick, modes 1 to 3 |

## Verification
A wrong prescale value, a wrong source selection or a swapped select changes the spacing of the pulses. That error shows up at the outputs within one bit period, which is at most 32 timer overflows or 64 clocks. A divider that does not clear on a configuration change gives no wrong period. It only delays the first pulse after the change by an amount that depends on the earlier history, so the bench leaves and re-enters one mode after two different dwell times and compares the two delays. A stuck or duplicated pulse shows within one or two cycles as a pair of adjacent high cycles.

// File: rtl/baud_pkg.sv
package baud_pkg;
  typedef enum logic [1:0] {
    SER_SYNC  = 2'd0,
    SER_TMR_A = 2'd1,
    SER_FIXED = 2'd2,
    SER_TMR_B = 2'd3
  } ser_mode_e;

  typedef struct packed {
    logic [1:0] mode;
    logic       dbl;
    logic       fast;
    logic       t2_tx;
    logic       t2_rx;
  } baud_cfg_t;
endpackage

// File: rtl/baud_div.sv
module baud_div #(
  parameter int MAX_DIV = 16,
  localparam int DW = $clog2(MAX_DIV + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          step,
  input  logic [DW-1:0] div,
  output logic          tick
);
  logic [DW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else begin
      tick <= 1'b0;
      if (step) begin
        if (cnt >= div - DW'(1)) begin
          cnt  <= '0;
          tick <= 1'b1;
        end else begin
          cnt <= cnt + DW'(1);
        end
      end
    end
  end

  // R10: a clear leaves the counter and tick at zero
  p_clear_zero_r10: assert property (@(posedge clk) disable iff (rst)
    $past(clr) |-> (cnt == '0 && !tick));

  // R8: the count never leaves its legal range
  p_cnt_bound_r8: assert property (@(posedge clk) disable iff (rst)
    cnt < DW'(MAX_DIV));
endmodule

// File: rtl/baud_path.sv
module baud_path #(
  parameter int OSR     = 16,
  parameter int MAX_PRE = 4,
  localparam int PW = $clog2(MAX_PRE + 1),
  localparam int OW = $clog2(OSR + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          src,
  input  logic [PW-1:0] pre_div,
  output logic          os_tick,
  output logic          bit_tick
);
  baud_div #(.MAX_DIV(MAX_PRE)) u_pre (
    .clk(clk), .rst(rst), .clr(clr), .step(src),
    .div(pre_div), .tick(os_tick)
  );

  baud_div #(.MAX_DIV(OSR)) u_bit (
    .clk(clk), .rst(rst), .clr(clr), .step(os_tick),
    .div(OW'(OSR)), .tick(bit_tick)
  );
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen #(
  parameter int SYNC_SLOW  = 12,
  parameter int SYNC_FAST  = 4,
  parameter int OSR        = 16,
  parameter int FIXED_SLOW = 64,
  parameter int FIXED_FAST = 32,
  parameter int TMR_SLOW   = 32,
  parameter int TMR_FAST   = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] mode,
  input  logic       dbl_rate,
  input  logic       fast_sync,
  input  logic       t1_ovf,
  input  logic       t2_ovf,
  input  logic       t2_tx_sel,
  input  logic       t2_rx_sel,
  output logic       tx_bit_en,
  output logic       rx_bit_en,
  output logic       rx_os_tick
);
  import baud_pkg::*;

  localparam int FIX_PRE_S = FIXED_SLOW / OSR;
  localparam int FIX_PRE_F = FIXED_FAST / OSR;
  localparam int TMR_PRE_S = TMR_SLOW / OSR;
  localparam int TMR_PRE_F = TMR_FAST / OSR;
  localparam int MAX_PRE   = (FIX_PRE_S > TMR_PRE_S) ? FIX_PRE_S : TMR_PRE_S;
  localparam int PW        = $clog2(MAX_PRE + 1);
  localparam int SYNC_MAX  = (SYNC_SLOW > SYNC_FAST) ? SYNC_SLOW : SYNC_FAST;
  localparam int SW        = $clog2(SYNC_MAX + 1);

  baud_cfg_t cfg_now, cfg_q;
  logic      chg;
  logic      is_sync;

  assign cfg_now = '{mode: mode, dbl: dbl_rate, fast: fast_sync,
                     t2_tx: t2_tx_sel, t2_rx: t2_rx_sel};
  assign chg     = (cfg_now != cfg_q);
  assign is_sync = (ser_mode_e'(mode) == SER_SYNC);

  always_ff @(posedge clk) begin
    if (rst) cfg_q <= '0;
    else     cfg_q <= cfg_now;
  end

  // Synchronous-mode divider shared by both directions
  logic          sync_tick;
  logic [SW-1:0] sync_div;
  assign sync_div = fast_sync ? SW'(SYNC_FAST) : SW'(SYNC_SLOW);

  baud_div #(.MAX_DIV(SYNC_MAX)) u_sync (
    .clk(clk), .rst(rst), .clr(chg), .step(is_sync),
    .div(sync_div), .tick(sync_tick)
  );

  // One prescale plus oversample chain per direction (0 = tx, 1 = rx)
  logic [1:0] t2_use;
  logic [1:0] os_v, bit_v;
  assign t2_use = {t2_rx_sel, t2_tx_sel};

  for (genvar d = 0; d < 2; d++) begin : g_dir
    logic          src;
    logic [PW-1:0] pre;

    always_comb begin
      src = 1'b0;
      pre = PW'(TMR_PRE_S);
      unique case (ser_mode_e'(mode))
        SER_FIXED: begin
          src = 1'b1;
          pre = dbl_rate ? PW'(FIX_PRE_F) : PW'(FIX_PRE_S);
        end
        SER_TMR_A, SER_TMR_B: begin
          src = t2_use[d] ? t2_ovf : t1_ovf;
          pre = (t2_use[d] || !dbl_rate) ? PW'(TMR_PRE_S) : PW'(TMR_PRE_F);
        end
        default: begin
          src = 1'b0;
          pre = PW'(TMR_PRE_S);
        end
      endcase
    end

    baud_path #(.OSR(OSR), .MAX_PRE(MAX_PRE)) u_path (
      .clk(clk), .rst(rst), .clr(chg), .src(src), .pre_div(pre),
      .os_tick(os_v[d]), .bit_tick(bit_v[d])
    );
  end

  logic path_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_bit_en  <= 1'b0;
      rx_bit_en  <= 1'b0;
      rx_os_tick <= 1'b0;
      path_q     <= 1'b0;
    end else begin
      tx_bit_en  <= is_sync ? sync_tick : bit_v[0];
      rx_bit_en  <= is_sync ? sync_tick : bit_v[1];
      rx_os_tick <= !is_sync && os_v[1];
      path_q     <= !is_sync;
    end
  end

  // R3: no oversample tick out of synchronous mode
  p_no_os_sync_r3: assert property (@(posedge clk) disable iff (rst)
    rx_os_tick |-> ($past(mode) != 2'd0));

  // R9: bit enables are single-cycle pulses
  p_tx_single_r9: assert property (@(posedge clk) disable iff (rst)
    tx_bit_en |=> !tx_bit_en);
  p_rx_single_r9: assert property (@(posedge clk) disable iff (rst)
    rx_bit_en |=> !rx_bit_en);

  // R8: a receive bit enable follows an oversample tick
  p_bit_after_os_r8: assert property (@(posedge clk) disable iff (rst)
    (rx_bit_en && path_q) |-> $past(rx_os_tick));
endmodule

// File: tb/baud_tick_gen_test.sv
module baud_tick_gen_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] mode = 2'd0;
  logic       dbl_rate = 1'b0, fast_sync = 1'b0;
  logic       t1_ovf, t2_ovf;
  logic       t2_tx_sel = 1'b0, t2_rx_sel = 1'b0;
  logic       tx_bit_en, rx_bit_en, rx_os_tick;

  localparam int T1P   = 3;
  localparam int T2P   = 5;
  localparam int LIMIT = 150000;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  int c1    = 0;
  int c2    = 0;

  always #10 clk = ~clk;

  baud_tick_gen uut (
    .clk(clk), .rst(rst), .mode(mode), .dbl_rate(dbl_rate),
    .fast_sync(fast_sync), .t1_ovf(t1_ovf), .t2_ovf(t2_ovf),
    .t2_tx_sel(t2_tx_sel), .t2_rx_sel(t2_rx_sel),
    .tx_bit_en(tx_bit_en), .rx_bit_en(rx_bit_en), .rx_os_tick(rx_os_tick)
  );

  assign t1_ovf = (c1 == 0);
  assign t2_ovf = (c2 == 0);

  always @(negedge clk) begin
    c1 <= (c1 == T1P - 1) ? 0 : c1 + 1;
    c2 <= (c2 == T2P - 1) ? 0 : c2 + 1;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > LIMIT) begin
      total++;
      bad++;
      $display("FAIL watchdog expired got=%0d exp=%0d", cyc, LIMIT);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input int got, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
    end
  endtask

  function automatic logic sig(input int which);
    case (which)
      0:       return tx_bit_en;
      1:       return rx_bit_en;
      default: return rx_os_tick;
    endcase
  endfunction

  task automatic setcfg(input logic [1:0] m, input logic d, input logic f,
                        input logic ts, input logic rs);
    @(negedge clk);
    mode = m; dbl_rate = d; fast_sync = f; t2_tx_sel = ts; t2_rx_sel = rs;
  endtask

  // Measures four consecutive intervals of one output
  task automatic meas(input int which, input int exp, input string tag);
    int  last = -1;
    int  n    = 0;
    int  got  = exp;
    bit  ok   = 1'b1;
    while (n < 5) begin
      @(negedge clk);
      if (sig(which)) begin
        if (last >= 0 && (cyc - last) != exp) begin
          ok  = 1'b0;
          got = cyc - last;
        end
        last = cyc;
        n++;
      end
    end
    check(ok, tag, got, exp);
  endtask

  task automatic first_delay(output int d);
    int start = cyc;
    d = -1;
    while (d < 0) begin
      @(negedge clk);
      if (tx_bit_en) d = cyc - start;
    end
  endtask

  initial begin
    int d1, d2, zeros, dup;
    // R11: reset state
    repeat (4) @(negedge clk);
    check(!tx_bit_en && !rx_bit_en && !rx_os_tick, "R11 outputs in reset",
          {tx_bit_en, rx_bit_en, rx_os_tick}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(!tx_bit_en && !rx_bit_en && !rx_os_tick, "R11 outputs after release",
          {tx_bit_en, rx_bit_en, rx_os_tick}, 0);

    // R1: mode 0, slow
    meas(0, 12, "R1 tx sync /12");
    meas(1, 12, "R1 rx sync /12");

    // R2, R3, R9: mode 0, fast
    setcfg(2'd0, 1'b0, 1'b1, 1'b0, 1'b0);
    meas(0, 4, "R2 tx sync /4");
    meas(1, 4, "R2 rx sync /4");
    zeros = 0;
    dup   = 0;
    for (int i = 0; i < 200; i++) begin
      logic ptx, prx;
      ptx = tx_bit_en;
      prx = rx_bit_en;
      @(negedge clk);
      if (rx_os_tick) zeros++;
      if ((ptx && tx_bit_en) || (prx && rx_bit_en)) dup++;
    end
    check(zeros == 0, "R3 os tick idle in sync mode", zeros, 0);
    check(dup == 0, "R9 no back-to-back enables", dup, 0);

    // R4: fixed division
    setcfg(2'd2, 1'b0, 1'b0, 1'b0, 1'b0);
    meas(0, 64, "R4 tx fixed /64");
    meas(2, 4, "R4 os fixed /4");
    setcfg(2'd2, 1'b1, 1'b0, 1'b0, 1'b0);
    meas(1, 32, "R4 rx fixed /32");
    meas(2, 2, "R4 os fixed /2");

    // R5, R8: first timer
    setcfg(2'd1, 1'b0, 1'b0, 1'b0, 1'b0);
    meas(0, 32 * T1P, "R5 tx timer1 x32");
    meas(1, 32 * T1P, "R5 rx timer1 x32");
    meas(2, 2 * T1P, "R8 os tick 16 per bit");
    setcfg(2'd3, 1'b1, 1'b0, 1'b0, 1'b0);
    meas(0, 16 * T1P, "R5 tx timer1 x16 dbl");

    // R6, R7: second timer on one side
    setcfg(2'd3, 1'b1, 1'b0, 1'b1, 1'b0);
    meas(0, 32 * T2P, "R6 tx timer2 ignores dbl");
    meas(1, 16 * T1P, "R7 rx stays timer1");
    setcfg(2'd1, 1'b0, 1'b0, 1'b0, 1'b1);
    meas(1, 32 * T2P, "R7 rx timer2");
    meas(0, 32 * T1P, "R7 tx stays timer1");
    setcfg(2'd1, 1'b1, 1'b0, 1'b0, 1'b1);
    meas(1, 32 * T2P, "R6 rx timer2 ignores dbl");

    // R10: restart on change gives a history-independent first delay
    setcfg(2'd2, 1'b0, 1'b0, 1'b0, 1'b0);
    repeat (100) @(negedge clk);
    setcfg(2'd0, 1'b0, 1'b0, 1'b0, 1'b0);
    repeat (7) @(negedge clk);
    setcfg(2'd2, 1'b0, 1'b0, 1'b0, 1'b0);
    first_delay(d1);
    repeat (150) @(negedge clk);
    setcfg(2'd0, 1'b0, 1'b0, 1'b0, 1'b0);
    repeat (23) @(negedge clk);
    setcfg(2'd2, 1'b0, 1'b0, 1'b0, 1'b0);
    first_delay(d2);
    check(d1 == d2, "R10 first pulse delay repeatable", d2, d1);
    check(d1 >= 64 && d1 <= 70, "R10 first pulse after one period", d1, 64);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule